// File: doc/BRIEF.md
# JTAG-to-Bus Bidirectional Mailbox

This block passes 32-bit words in both directions between a JTAG test access port and a memory-mapped register bus. Software posts an outbound word with a bus write. A debugger collects that word through a JTAG data register that it selects with the outbound-read opcode. In the other direction, a debugger shifts an inbound word in through a second data register, and software then reads it over the bus. The TAP controller is outside the block. The block takes per-state indications for Capture-DR, Shift-DR and Update-DR, together with the 5-bit instruction register value.

Each direction has a sticky ready flag, and each flag is held by a two-state machine in the bus domain. The outbound machine moves from `OUT_EMPTY` to `OUT_FULL` on a bus write to the outbound register. It stays in `OUT_FULL` when a further write overwrites the word. It returns to `OUT_EMPTY` when a "taken" event arrives from the TCK domain. The inbound machine moves from `IN_EMPTY` to `IN_FULL` when an "arrived" event comes from the TCK domain. It returns to `IN_EMPTY` when the bus reads the inbound register. If an arrival and a read fall in the same bus cycle, the arrival wins.

Events cross between the two clock domains as toggles, each received through two synchronising flops and an edge detector, so no event is lost. The flag levels reach the TCK domain through two-flop synchronisers, where they are folded into the outbound shift frame. Each side can therefore poll the state of the other.

Top module: `jtag_mailbox`

## Requirements
- R1: After reset, the status register, the outbound register and the inbound register all read 0 over the bus, and `tdo` is 0.
- R2: A bus write to address 0 stores the word, which reads back from address 0, and sets outbound-ready. Outbound-ready is status bit 0.
- R3: A bus write to address 0 while outbound-ready is already set replaces the stored word and leaves outbound-ready set.
- R4: With opcode 5'b00010, the Capture-DR edge loads a 34-bit frame that then shifts out on `tdo`, LSB first, during Shift-DR. Bits 31:0 carry the outbound word, bit 32 carries outbound-ready and bit 33 carries inbound-ready.
- R5: Leaving Capture-DR under opcode 5'b00010 clears outbound-ready.
- R6: With opcode 5'b00011, 32 bits shift in from `tdi`, LSB first, during Shift-DR. The Update-DR edge copies them into the inbound register at bus address 1 and sets inbound-ready, which is status bit 1.
- R7: A bus read of address 1 clears inbound-ready. A read of the status register (address 2) leaves both flags unchanged.
- R8: Frame bit 33 follows inbound-ready. It reads 1 while an inbound word is unread and 0 after software has read it.
- R9: Under opcode 5'b00001 or any other opcode besides 5'b00010 and 5'b00011, `tdo` stays 0 and Capture-DR, Shift-DR and Update-DR change neither flag nor the inbound register.
- R10: Shifting under opcode 5'b00011 with no Update-DR leaves the inbound register and inbound-ready unchanged.
- R11: Status bits 31:2 read 0, address 3 reads 0, and `bus_rdata` is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | 0 outbound, 1 inbound, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| tck | input | 1 | JTAG test clock |
| tdi | input | 1 | JTAG serial input |
| tdo | output | 1 | JTAG serial output |
| ir_value | input | 5 | Current instruction register value |
| st_capture_dr | input | 1 | TAP is in Capture-DR |
| st_shift_dr | input | 1 | TAP is in Shift-DR |
| st_update_dr | input | 1 | TAP is in Update-DR |

## Verification
A table of word pairs runs a full round trip in both directions. The pairs are all zeros against all ones, alternating bit patterns, and single set bits at each end. Together they separate a correct LSB-first order from a reversed or misaligned shift, and a stuck frame bit from a working one. Directed cases then cover the following: two writes back to back (overwrite, flag held); an unread inbound word seen through frame bit 33 before and after the software read; status reads that must not clear flags; the reserved opcode and an undefined opcode; and shifting with no update. These cases tell apart the flag events that a given access must cause from those it must not.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int OPC_W = 5;
    localparam logic [OPC_W-1:0] OPC_RESERVED = 5'b00001;
    localparam logic [OPC_W-1:0] OPC_OUT_READ = 5'b00010;
    localparam logic [OPC_W-1:0] OPC_IN_WRITE = 5'b00011;

    localparam logic [1:0] ADDR_OUT  = 2'd0;
    localparam logic [1:0] ADDR_IN   = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef enum logic { OUT_EMPTY, OUT_FULL } out_state_t;
    typedef enum logic { IN_EMPTY,  IN_FULL  } in_state_t;
    typedef enum logic [1:0] { DR_NONE, DR_OUT, DR_IN } dr_sel_t;
endpackage

// File: rtl/mbox_sync2.sv
module mbox_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/mbox_toggle_rx.sv
module mbox_toggle_rx (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl,
    output logic pulse
);
    logic synced;
    logic last;

    mbox_sync2 #(.W(1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tgl),
        .q     (synced)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b0;
        else        last <= synced;
    end

    assign pulse = synced ^ last;
endmodule

// File: rtl/mbox_tap_side.sv
module mbox_tap_side
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              tdi,
    input  logic [OPC_W-1:0]  ir_value,
    input  logic              st_capture_dr,
    input  logic              st_shift_dr,
    input  logic              st_update_dr,
    input  logic [DATA_W-1:0] out_word,
    input  logic              out_rdy_t,
    input  logic              in_rdy_t,
    output logic              tdo,
    output logic [DATA_W-1:0] in_hold,
    output logic              out_taken_tgl,
    output logic              in_new_tgl
);
    localparam int FRAME_W = DATA_W + 2;

    dr_sel_t             dr_sel;
    logic [FRAME_W-1:0]  out_sr;
    logic [DATA_W-1:0]   in_sr;

    always_comb begin
        case (ir_value)
            OPC_OUT_READ: dr_sel = DR_OUT;
            OPC_IN_WRITE: dr_sel = DR_IN;
            default:      dr_sel = DR_NONE;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            out_sr        <= '0;
            out_taken_tgl <= 1'b0;
        end else if (dr_sel == DR_OUT) begin
            if (st_capture_dr) begin
                out_sr        <= {in_rdy_t, out_rdy_t, out_word};
                out_taken_tgl <= ~out_taken_tgl;
            end else if (st_shift_dr) begin
                out_sr <= {tdi, out_sr[FRAME_W-1:1]};
            end
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            in_sr      <= '0;
            in_hold    <= '0;
            in_new_tgl <= 1'b0;
        end else if (dr_sel == DR_IN) begin
            if (st_capture_dr) begin
                in_sr <= in_hold;
            end else if (st_shift_dr) begin
                in_sr <= {tdi, in_sr[DATA_W-1:1]};
            end else if (st_update_dr) begin
                in_hold    <= in_sr;
                in_new_tgl <= ~in_new_tgl;
            end
        end
    end

    always_comb begin
        unique case (dr_sel)
            DR_OUT:  tdo = out_sr[0];
            DR_IN:   tdo = in_sr[0];
            default: tdo = 1'b0;
        endcase
    end
endmodule

// File: rtl/mbox_bus_side.sv
module mbox_bus_side
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] in_hold,
    input  logic              out_taken_pulse,
    input  logic              in_new_pulse,
    output logic [DATA_W-1:0] out_word,
    output logic              out_rdy,
    output logic              in_rdy
);
    out_state_t out_state, out_next;
    in_state_t  in_state,  in_next;

    logic out_post;
    logic in_fetch;

    assign out_post = bus_sel &&  bus_wr && (bus_addr == ADDR_OUT);
    assign in_fetch = bus_sel && !bus_wr && (bus_addr == ADDR_IN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_state <= OUT_EMPTY;
            in_state  <= IN_EMPTY;
            out_word  <= '0;
        end else begin
            out_state <= out_next;
            in_state  <= in_next;
            if (out_post) out_word <= bus_wdata;
        end
    end

    always_comb begin
        out_next = out_state;
        unique case (out_state)
            OUT_EMPTY: if (out_post) out_next = OUT_FULL;
            OUT_FULL:  if (!out_post && out_taken_pulse) out_next = OUT_EMPTY;
        endcase
    end

    always_comb begin
        in_next = in_state;
        unique case (in_state)
            IN_EMPTY: if (in_new_pulse) in_next = IN_FULL;
            IN_FULL:  if (in_fetch && !in_new_pulse) in_next = IN_EMPTY;
        endcase
    end

    always_comb begin
        out_rdy   = (out_state == OUT_FULL);
        in_rdy    = (in_state == IN_FULL);
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADDR_OUT:  bus_rdata = out_word;
                ADDR_IN:   bus_rdata = in_hold;
                ADDR_STAT: bus_rdata = {{(DATA_W-2){1'b0}}, in_rdy, out_rdy};
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/jtag_mailbox.sv
module jtag_mailbox
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tck,
    input  logic              tdi,
    output logic              tdo,
    input  logic [OPC_W-1:0]  ir_value,
    input  logic              st_capture_dr,
    input  logic              st_shift_dr,
    input  logic              st_update_dr
);
    logic [DATA_W-1:0] out_word;
    logic [DATA_W-1:0] in_hold;
    logic              out_rdy, in_rdy;
    logic [1:0]        flags_t;
    logic              out_taken_tgl, in_new_tgl;
    logic              out_taken_pulse, in_new_pulse;

    mbox_sync2 #(.W(2)) u_flag_sync (
        .clk   (tck),
        .rst_n (rst_n),
        .d     ({in_rdy, out_rdy}),
        .q     (flags_t)
    );

    mbox_toggle_rx u_taken_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tgl   (out_taken_tgl),
        .pulse (out_taken_pulse)
    );

    mbox_toggle_rx u_new_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tgl   (in_new_tgl),
        .pulse (in_new_pulse)
    );

    mbox_tap_side #(.DATA_W(DATA_W)) u_tap (
        .tck           (tck),
        .rst_n         (rst_n),
        .tdi           (tdi),
        .ir_value      (ir_value),
        .st_capture_dr (st_capture_dr),
        .st_shift_dr   (st_shift_dr),
        .st_update_dr  (st_update_dr),
        .out_word      (out_word),
        .out_rdy_t     (flags_t[0]),
        .in_rdy_t      (flags_t[1]),
        .tdo           (tdo),
        .in_hold       (in_hold),
        .out_taken_tgl (out_taken_tgl),
        .in_new_tgl    (in_new_tgl)
    );

    mbox_bus_side #(.DATA_W(DATA_W)) u_bus (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_sel         (bus_sel),
        .bus_wr          (bus_wr),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .in_hold         (in_hold),
        .out_taken_pulse (out_taken_pulse),
        .in_new_pulse    (in_new_pulse),
        .out_word        (out_word),
        .out_rdy         (out_rdy),
        .in_rdy          (in_rdy)
    );
endmodule

// File: rtl/jtag_mailbox_chk.sv
module jtag_mailbox_chk
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              tck,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic              tdo,
    input logic [OPC_W-1:0]  ir_value,
    input logic              st_capture_dr,
    input logic              st_update_dr,
    input logic              out_rdy,
    input logic              in_rdy,
    input logic              in_new_pulse,
    input logic [DATA_W-1:0] in_hold,
    input logic [DATA_W-1:0] out_word
);
    p_wr_sets_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_OUT) |=> out_rdy);

    p_out_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_rdy) |-> $past(bus_sel && bus_wr && bus_addr == ADDR_OUT));

    p_in_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_new_pulse |=> in_rdy);

    p_read_clears_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_IN && !in_new_pulse) |=> !in_rdy);

    p_capture_lsb_r4: assert property (@(posedge tck) disable iff (!rst_n)
        (st_capture_dr && ir_value == OPC_OUT_READ)
        |=> (ir_value != OPC_OUT_READ) || (tdo == $past(out_word[0])));

    p_idle_tdo_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_value != OPC_OUT_READ && ir_value != OPC_IN_WRITE) |-> !tdo);

    p_hold_needs_update_r10: assert property (@(posedge tck) disable iff (!rst_n)
        !(st_update_dr && ir_value == OPC_IN_WRITE) |=> $stable(in_hold));
endmodule

bind jtag_mailbox jtag_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .tck           (tck),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .tdo           (tdo),
    .ir_value      (ir_value),
    .st_capture_dr (st_capture_dr),
    .st_update_dr  (st_update_dr),
    .out_rdy       (out_rdy),
    .in_rdy        (in_rdy),
    .in_new_pulse  (in_new_pulse),
    .in_hold       (in_hold),
    .out_word      (out_word)
);

// File: tb/jtag_mailbox_test.sv
module jtag_mailbox_test;
    localparam int DW = 32;
    localparam int NV = 4;
    localparam logic [4:0] OP_OUT = 5'b00010;
    localparam logic [4:0] OP_IN  = 5'b00011;
    localparam logic [4:0] OP_RSV = 5'b00001;
    localparam logic [4:0] OP_UND = 5'b10101;

    // each entry: {outbound word, inbound word}
    localparam logic [63:0] VEC [NV] = '{
        {32'h0000_0000, 32'hFFFF_FFFF},
        {32'hA5A5_5A5A, 32'h5A5A_A5A5},
        {32'h8000_0000, 32'h0000_0001},
        {32'h1234_5678, 32'hCAFE_F00D}
    };

    logic clk = 0, tck = 0, rst_n = 0;
    logic bus_sel = 0, bus_wr = 0;
    logic [1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic tdi = 0, tdo;
    logic [4:0] ir_value = '0;
    logic st_capture_dr = 0, st_shift_dr = 0, st_update_dr = 0;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #4  clk = ~clk;
    always #10 tck = ~tck;

    jtag_mailbox #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tck(tck), .tdi(tdi), .tdo(tdo), .ir_value(ir_value),
        .st_capture_dr(st_capture_dr), .st_shift_dr(st_shift_dr),
        .st_update_dr(st_update_dr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge tck);
    endtask

    // capture, shift nbits with din on tdi, optional update; tdo bits collected in dout
    task automatic jtag_dr(input logic [4:0] op, input logic [33:0] din, input int nbits,
                           input bit upd, output logic [33:0] dout);
        dout = '0;
        @(negedge tck);
        ir_value = op; st_capture_dr = 1;
        @(negedge tck);
        st_capture_dr = 0; st_shift_dr = 1;
        for (int i = 0; i < nbits; i++) begin
            tdi = din[i];
            #1 dout[i] = tdo;
            @(negedge tck);
        end
        st_shift_dr = 0;
        st_update_dr = upd;
        @(negedge tck);
        st_update_dr = 0; tdi = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        logic [33:0]   f;
        logic [DW-1:0] last_in;

        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1 reset state
        bus_read(2'd2, v); check("R1 status", v, 0);
        bus_read(2'd0, v); check("R1 outbound", v, 0);
        bus_read(2'd1, v); check("R1 inbound", v, 0);
        check("R1 tdo", tdo, 0);
        // R11 idle rdata and address 3
        check("R11 idle rdata", bus_rdata, 0);
        bus_read(2'd3, v); check("R11 addr3", v, 0);

        for (int k = 0; k < NV; k++) begin
            bus_write(2'd0, VEC[k][63:32]);
            bus_read(2'd0, v);  check("R2 readback", v, VEC[k][63:32]);
            bus_read(2'd2, v);  check("R2 out flag", v, 32'h1);
            settle();
            jtag_dr(OP_OUT, '0, 34, 1'b1, f);
            check("R4 frame data", f[31:0], VEC[k][63:32]);
            check("R4 frame out_rdy", f[32], 1);
            check("R8 frame in_rdy empty", f[33], 0);
            settle();
            bus_read(2'd2, v);  check("R5 out cleared", v, 0);

            jtag_dr(OP_IN, {2'b00, VEC[k][31:0]}, 32, 1'b1, f);
            settle();
            bus_read(2'd2, v);  check("R6 in flag", v, 32'h2);
            bus_read(2'd1, v);  check("R6 inbound word", v, VEC[k][31:0]);
            bus_read(2'd2, v);  check("R7 in cleared", v, 0);
        end
        last_in = VEC[NV-1][31:0];

        // R3 overwrite while full
        bus_write(2'd0, 32'h1111_2222);
        bus_write(2'd0, 32'h3333_4444);
        bus_read(2'd2, v); check("R3 flag held", v, 32'h1);
        bus_read(2'd0, v); check("R3 overwritten", v, 32'h3333_4444);
        settle();
        jtag_dr(OP_OUT, '0, 34, 1'b1, f);
        check("R3 frame data", f[31:0], 32'h3333_4444);
        settle();

        // R7 status reads keep flags; R8 frame bit 33 tracks in_rdy
        jtag_dr(OP_IN, {2'b00, 32'h0BAD_BEEF}, 32, 1'b1, f);
        settle();
        bus_read(2'd2, v); bus_read(2'd2, v);
        check("R7 status read keeps flag", v, 32'h2);
        jtag_dr(OP_OUT, '0, 34, 1'b1, f);
        check("R8 frame in_rdy set", f[33:32], 2'b10);
        bus_read(2'd1, v); check("R6 second word", v, 32'h0BAD_BEEF);
        last_in = 32'h0BAD_BEEF;
        settle();
        jtag_dr(OP_OUT, '0, 34, 1'b1, f);
        check("R8 frame in_rdy cleared", f[33], 0);
        settle();

        // R9 reserved and undefined opcodes
        bus_write(2'd0, 32'hDEAD_0001);
        settle();
        jtag_dr(OP_RSV, 34'h3_FFFF_FFFF, 34, 1'b1, f);
        check("R9 reserved tdo", f, 0);
        jtag_dr(OP_UND, 34'h3_FFFF_FFFF, 34, 1'b1, f);
        check("R9 undefined tdo", f, 0);
        settle();
        bus_read(2'd2, v); check("R9 flags untouched", v, 32'h1);
        bus_read(2'd1, v); check("R9 inbound untouched", v, last_in);

        // R10 shift without update
        jtag_dr(OP_IN, {2'b00, 32'h7777_8888}, 32, 1'b0, f);
        settle();
        bus_read(2'd2, v); check("R10 no in flag", v, 32'h1);
        bus_read(2'd1, v); check("R10 inbound unchanged", v, last_in);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule